// File: doc/BRIEF.md
# Open-Drain Data Line Repeater with Master Election

This block joins two open-drain data lines, one on the host side and one on the card side, each with its own pull-up. Either side may start a low pulse. The block samples both lines. The side whose line falls first becomes the master for that exchange. After a programmable delay the block pulls the other side, the slave, low. When the master lets its line go high again, the block stops pulling the slave low. It then drives the slave side high for a short, fixed number of cycles so the line recovers quickly, and both sides return to the released state.

Both pin inputs pass through a synchronizer before any decision is made. While a session runs, the slave side's own level is ignored. No new session can begin until the high-drive pulse has finished. An `enable` input shows whether the card interface is powered. While it is low, the card line is clamped low, the host line is left released, and any session in progress is dropped.

The block carries no data stream. It relays a line level only, so every pin is a plain level and no valid/ready handshake is needed.

Top module: `odline_repeater`

## Requirements
- R1: With `enable` high and no session running, all four drive outputs (`host_pull_low`, `host_push_high`, `card_pull_low`, `card_push_high`) are 0. This is the state seen after reset.
- R2: In the idle state, the first side whose synchronized level goes from 1 to 0 becomes master. If both sides fall in the same cycle, the host side becomes master.
- R3: Each pin passes through `SYNC_STAGES` flip-flops. If the master pin falls just before clock edge 1, the slave's pull-low output is first seen high after edge `SYNC_STAGES + 1 + DLY_CYC`.
- R4: While a session is active, level changes on the slave side do not start a session and do not change any output. The block never drives the master side.
- R5: If the master is held low across L clock edges with L > `DLY_CYC`, the slave pull-low lasts exactly L − `DLY_CYC` cycles. The slave push-high then starts after edge L + `SYNC_STAGES` + 1 and lasts exactly `PU_CYC` cycles. After that, all outputs return to 0.
- R6: If the master is released with L ≤ `DLY_CYC`, the slave is never pulled low, no push-high pulse is produced, and the block returns to idle.
- R7: A falling edge on either side during the push-high pulse does not start a new session.
- R8: While `enable` is 0, `card_pull_low` is 1 and the other three outputs are 0. Any session in progress is abandoned. When `enable` goes high again, the card line rising does not start a session.
- R9: The block never pulls low on both sides at once, and never pulls low and pushes high on the same side at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Card interface powered; 0 clamps the card line low |
| host_in | input | 1 | Sensed level of the host-side line |
| card_in | input | 1 | Sensed level of the card-side line |
| host_pull_low | output | 1 | Open-drain pull-down on the host line |
| host_push_high | output | 1 | Active high drive on the host line |
| card_pull_low | output | 1 | Open-drain pull-down on the card line |
| card_push_high | output | 1 | Active high drive on the card line |

## Verification
The hardest situations to reach are the ones where timing overlaps: a master released right at the end of the copy delay, a second fall arriving inside the push-high pulse, and a simultaneous fall on both sides. The bench models both wired lines, so the block's own drives feed back onto its inputs. It then sweeps the master hold length across the point where the delay expires, for each side. For each length it counts the exact number of pull and push cycles expected. Further runs inject a slave glitch, a re-fall during the pulse, a tie, and an `enable` drop in the middle of a session.

// File: rtl/odline_pkg.sv
package odline_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_DRIVE = 2'd2,
    PH_PULSE = 2'd3
  } phase_t;

  typedef enum logic {
    SIDE_HOST = 1'b0,
    SIDE_CARD = 1'b1
  } side_t;
endpackage

// File: rtl/odline_sync.sv
module odline_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic fell
);
  logic prev_q;

  generate
    if (STAGES <= 1) begin : g_single
      logic st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= 1'b1;
        else        st_q <= pin;
      end
      assign level = st_q;
    end else begin : g_chain
      logic [STAGES-1:0] st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= {st_q[STAGES-2:0], pin};
      end
      assign level = st_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level;
  end

  assign fell = prev_q & ~level;
endmodule

// File: rtl/odline_timer.sv
module odline_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  a_r5_timer_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/odline_fsm.sv
module odline_fsm
  import odline_pkg::*;
#(
  parameter int DLY_CYC = 20,
  parameter int PU_CYC  = 10,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          host_lvl,
  input  logic          card_lvl,
  input  logic          host_fell,
  input  logic          card_fell,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output phase_t        phase,
  output side_t         master
);
  localparam logic [CW-1:0] DLY_LOAD = CW'(DLY_CYC - 1);
  localparam logic [CW-1:0] PU_LOAD  = CW'(PU_CYC - 1);

  phase_t phase_q, phase_d;
  side_t  master_q, master_d;
  logic   master_released;

  assign master_released = (master_q == SIDE_HOST) ? host_lvl : card_lvl;

  always_comb begin
    phase_d  = phase_q;
    master_d = master_q;
    tmr_load = 1'b0;
    tmr_val  = DLY_LOAD;
    if (!enable) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (host_fell) begin
            phase_d  = PH_WAIT;
            master_d = SIDE_HOST;
            tmr_load = 1'b1;
          end else if (card_fell) begin
            phase_d  = PH_WAIT;
            master_d = SIDE_CARD;
            tmr_load = 1'b1;
          end
        end
        PH_WAIT: begin
          if (master_released)  phase_d = PH_IDLE;
          else if (tmr_expired) phase_d = PH_DRIVE;
        end
        PH_DRIVE: begin
          if (master_released) begin
            phase_d  = PH_PULSE;
            tmr_load = 1'b1;
            tmr_val  = PU_LOAD;
          end
        end
        PH_PULSE: begin
          if (tmr_expired) phase_d = PH_IDLE;
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      master_q <= SIDE_HOST;
    end else begin
      phase_q  <= phase_d;
      master_q <= master_d;
    end
  end

  assign phase  = phase_q;
  assign master = master_q;

  a_r2_master_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(master_q));
  a_r2_host_wins_tie: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) == PH_IDLE && phase_q == PH_WAIT && $past(host_fell)) |-> (master_q == SIDE_HOST));
  a_r3_drive_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DRIVE && $past(phase_q) != PH_DRIVE) |-> ($past(phase_q) == PH_WAIT));
  a_r5_pulse_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PULSE && $past(phase_q) != PH_PULSE) |-> ($past(phase_q) == PH_DRIVE));
  a_r7_no_election_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PULSE) |=> (phase_q == PH_PULSE || phase_q == PH_IDLE));
endmodule

// File: rtl/odline_repeater.sv
module odline_repeater
  import odline_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_CYC     = 20,
  parameter int PU_CYC      = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic host_in,
  input  logic card_in,
  output logic host_pull_low,
  output logic host_push_high,
  output logic card_pull_low,
  output logic card_push_high
);
  localparam int MAXC = (DLY_CYC > PU_CYC) ? DLY_CYC : PU_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          host_lvl, card_lvl, host_fell, card_fell;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;
  phase_t        phase;
  side_t         master;

  odline_sync #(.STAGES(SYNC_STAGES)) u_sync_host (
    .clk(clk), .rst_n(rst_n), .pin(host_in), .level(host_lvl), .fell(host_fell)
  );
  odline_sync #(.STAGES(SYNC_STAGES)) u_sync_card (
    .clk(clk), .rst_n(rst_n), .pin(card_in), .level(card_lvl), .fell(card_fell)
  );

  odline_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  odline_fsm #(.DLY_CYC(DLY_CYC), .PU_CYC(PU_CYC), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .host_lvl(host_lvl), .card_lvl(card_lvl),
    .host_fell(host_fell), .card_fell(card_fell),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .phase(phase), .master(master)
  );

  assign host_pull_low  = enable && (phase == PH_DRIVE) && (master == SIDE_CARD);
  assign host_push_high = enable && (phase == PH_PULSE) && (master == SIDE_CARD);
  assign card_pull_low  = !enable || ((phase == PH_DRIVE) && (master == SIDE_HOST));
  assign card_push_high = enable && (phase == PH_PULSE) && (master == SIDE_HOST);

  a_r8_disabled_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (card_pull_low && !card_push_high && !host_pull_low && !host_push_high));
  a_r9_one_side_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pull_low && card_pull_low));
  a_r9_no_fight_host: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_pull_low && host_push_high));
  a_r9_no_fight_card: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_pull_low && card_push_high));
  a_r5_push_follows_pull: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_push_high) |-> $past(card_pull_low));
endmodule

// File: tb/odline_repeater_bench.sv
module odline_repeater_bench;
  localparam int SYNC = 2;
  localparam int DLY  = 5;
  localparam int PU   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic host_ext_low = 1'b0;
  logic card_ext_low = 1'b0;
  logic host_pull_low, host_push_high, card_pull_low, card_push_high;
  logic host_in, card_in;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign host_in = !(host_ext_low || host_pull_low);
  assign card_in = !(card_ext_low || card_pull_low);

  odline_repeater #(.SYNC_STAGES(SYNC), .DLY_CYC(DLY), .PU_CYC(PU)) u_odline_repeater (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .host_in(host_in), .card_in(card_in),
    .host_pull_low(host_pull_low), .host_push_high(host_push_high),
    .card_pull_low(card_pull_low), .card_push_high(card_push_high)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Master held low across L edges; counts slave/master drives over a window.
  task automatic session(input bit host_master, input bit tie, input int L,
                         input bit glitch, input bit refall);
    int sp = 0, su = 0, mp = 0, mu = 0;
    int sp_first = -1, su_first = -1;
    int exp_sp, exp_su;
    if (host_master) host_ext_low = 1'b1; else card_ext_low = 1'b1;
    if (tie) card_ext_low = 1'b1;
    for (int k = 1; k <= L + PU + 8; k++) begin
      step();
      if (host_master) begin
        if (card_pull_low)  begin sp++; if (sp_first < 0) sp_first = k; end
        if (card_push_high) begin su++; if (su_first < 0) su_first = k; end
        if (host_pull_low)  mp++;
        if (host_push_high) mu++;
      end else begin
        if (host_pull_low)  begin sp++; if (sp_first < 0) sp_first = k; end
        if (host_push_high) begin su++; if (su_first < 0) su_first = k; end
        if (card_pull_low)  mp++;
        if (card_push_high) mu++;
      end
      if (k == L) begin host_ext_low = 1'b0; card_ext_low = 1'b0; end
      if (glitch && k == 3) begin if (host_master) card_ext_low = 1'b1; else host_ext_low = 1'b1; end
      if (glitch && k == 6) begin if (host_master) card_ext_low = 1'b0; else host_ext_low = 1'b0; end
      if (refall && k == L + 2) begin if (host_master) host_ext_low = 1'b1; else card_ext_low = 1'b1; end
      if (refall && k == L + 4) begin host_ext_low = 1'b0; card_ext_low = 1'b0; end
    end
    exp_sp = (L > DLY) ? L - DLY : 0;
    exp_su = (L > DLY) ? PU : 0;
    if (L > DLY) begin
      chk(sp == exp_sp, "R5 slave pull-low length", sp, exp_sp);
      chk(su == exp_su, "R5 push-high length", su, exp_su);
      chk(sp_first == SYNC + 1 + DLY, "R3 copy latency", sp_first, SYNC + 1 + DLY);
      chk(su_first == L + SYNC + 1, "R5 push-high start", su_first, L + SYNC + 1);
    end else begin
      chk(sp == 0, "R6 no slave drive on early release", sp, 0);
      chk(su == 0, "R6 no push on early release", su, 0);
    end
    chk(mp == 0 && mu == 0, "R4 master side never driven", mp + mu, 0);
    chk(!host_pull_low && !host_push_high && !card_pull_low && !card_push_high,
        "R1 idle after session", int'(host_pull_low) + int'(card_pull_low), 0);
  endtask

  initial begin
    repeat (3) step();
    enable = 1'b1;
    rst_n = 1'b1;
    step();
    chk(!host_pull_low && !host_push_high && !card_pull_low && !card_push_high,
        "R1 reset state", int'(host_pull_low) + int'(card_pull_low), 0);

    // R2 R3 R5 R6: sweep the hold length on each side.
    for (int L = 1; L <= 10; L++) session(1'b1, 1'b0, L, 1'b0, 1'b0);
    for (int L = 1; L <= 10; L++) session(1'b0, 1'b0, L, 1'b0, 1'b0);

    // R2: tie goes to the host side.
    session(1'b1, 1'b1, 3, 1'b0, 1'b0);
    session(1'b1, 1'b1, 9, 1'b0, 1'b0);

    // R4: slave-side glitches during a session.
    session(1'b1, 1'b0, 12, 1'b1, 1'b0);
    session(1'b0, 1'b0, 12, 1'b1, 1'b0);

    // R7: a second fall on the master during the pulse.
    session(1'b1, 1'b0, 8, 1'b0, 1'b1);
    session(1'b0, 1'b0, 8, 1'b0, 1'b1);

    // R8: disabled clamp, host fall ignored.
    begin
      int bad = 0;
      enable = 1'b0;
      step();
      host_ext_low = 1'b1;
      for (int k = 0; k < 10; k++) begin
        step();
        if (!card_pull_low || card_push_high || host_pull_low || host_push_high) bad++;
      end
      host_ext_low = 1'b0;
      chk(bad == 0, "R8 clamp while disabled", bad, 0);
    end

    // R8: drop enable mid-session, then re-enable.
    begin
      int bad = 0, spur = 0;
      enable = 1'b1;
      repeat (6) step();
      host_ext_low = 1'b1;
      for (int k = 1; k <= 10; k++) step();
      chk(card_pull_low, "R3 drive before abort", int'(card_pull_low), 1);
      enable = 1'b0;
      for (int k = 0; k < 4; k++) begin
        step();
        if (!card_pull_low || card_push_high || host_pull_low || host_push_high) bad++;
      end
      host_ext_low = 1'b0;
      repeat (4) step();
      chk(bad == 0, "R8 abort clamps card", bad, 0);
      enable = 1'b1;
      for (int k = 0; k < 20; k++) begin
        step();
        if (host_pull_low || host_push_high || card_pull_low || card_push_high) spur++;
      end
      chk(spur == 0, "R8 no session on re-enable", spur, 0);
    end

    // A normal session still works afterwards.
    session(1'b0, 1'b0, 7, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule